// File: doc/BRIEF.md
# Multi-Slave Two-Acknowledge Strobe Handshake

This block moves a sequence of words from one master to a group of slaves over a single strobe line and a shared data bus. The master puts a word on the bus and flips the strobe, so each edge of the strobe carries one word, whether the edge is rising or falling. Every slave captures the word and, after its own response latency, raises one of two acknowledge lines. The master sees each acknowledge line as the AND of that line over all slaves. It therefore finishes a transfer only when the slowest slave has answered.

The two acknowledge lines take turns. A transfer on a rising strobe edge completes on a rising edge of the first combined line. A transfer on a falling strobe edge completes on a rising edge of the second. When a slave captures a word, it clears the line that is not in use, which arms that line for the next transfer. The master relies only on rising edges of the combined lines. A falling edge of an AND-combined line only shows that some slave has dropped, so it cannot signal that all of them are done. The whole block is synchronous to one clock, and slave latencies are parameters.

Top module: `hs_bus`

## Requirements
- R1: While reset is held and in the first cycle after it, strobe_o, ack_even_o, ack_odd_o and done_o are 0 and req_ready_o is 1.
- R2: A request is taken only when req_valid_i and req_ready_o are both 1 at a clock edge. After that edge strobe_o is inverted, bus_data_o holds req_data_i and req_ready_o is 0. A request raised while req_ready_o is 0 leaves strobe_o and bus_data_o unchanged.
- R3: bus_data_o stays unchanged from the edge that takes a request until done_o is seen for that transfer.
- R4: One cycle after a strobe change, every slave pulses its bit of slv_valid_o for one cycle. Its slice of slv_data_o (slave s at bits s*DW and up) then holds the bus word.
- R5: Slave s raises its acknowledge LAT_BASE+s*LAT_STEP+1 cycles after capture. A combined line is 1 only when all slaves have raised it, so it rises LMAX+2 cycles after the request edge, where LMAX is the largest slave latency.
- R6: Transfers alternate, starting with the first transfer after reset. Odd-numbered transfers use a 0-to-1 strobe edge and complete on ack_even_o. Even-numbered transfers use a 1-to-0 edge and complete on ack_odd_o. Capture clears the other line, and the two combined lines are never 1 together.
- R7: done_o pulses for one cycle, LMAX+3 cycles after the edge that took the request. req_ready_o returns to 1 in that same cycle.
- R8: A reset in the middle of a transfer returns the block to the R1 state. The next transfer again uses a rising strobe and ack_even_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Master has a word to send |
| req_data_i | input | DW | Word to send |
| req_ready_o | output | 1 | Master idle, can take a request |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| strobe_o | output | 1 | Strobe line; each edge carries a word |
| bus_data_o | output | DW | Address/data bus |
| ack_even_o | output | 1 | AND over slaves of the first acknowledge line |
| ack_odd_o | output | 1 | AND over slaves of the second acknowledge line |
| slv_data_o | output | NS*DW | Word captured by each slave |
| slv_valid_o | output | NS | Per-slave capture pulse |

## Verification
The bench builds the block with three 16-bit slaves, LAT_BASE=1 and LAT_STEP=2, so the latencies are 1, 3 and 5 cycles. Because the latencies differ, there is a window in which the faster slaves have acknowledged and the combined line is still low. The bench checks, cycle by cycle, that completion waits for the slowest slave. Runs of several transfers exercise both strobe polarities and both acknowledge lines. The bench also checks that a request made during a busy transfer is ignored and that a reset in the middle of a transfer restarts the phase sequence.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned ACK_LINES = 2;

  function automatic int unsigned slave_lat(int unsigned base, int unsigned step, int unsigned idx);
    return base + idx * step;
  endfunction
endpackage

// File: rtl/hs_master.sv
module hs_master #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [DW-1:0] req_data_i,
  output logic          req_ready_o,
  input  logic [1:0]    ack_i,
  output logic          strobe_o,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic          busy_q, ph_q, strobe_q, done_q;
  logic [DW-1:0] data_q;
  logic [1:0]    ack_prev_q;
  logic          accept, ack_rise;

  assign accept   = req_valid_i & ~busy_q;
  // only a rising edge of the combined line proves every slave has answered
  assign ack_rise = ack_i[ph_q] & ~ack_prev_q[ph_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      strobe_q   <= 1'b0;
      done_q     <= 1'b0;
      data_q     <= '0;
      ack_prev_q <= '0;
    end else begin
      ack_prev_q <= ack_i;
      done_q     <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        strobe_q <= ~strobe_q;
        data_q   <= req_data_i;
      end else if (busy_q && ack_rise) begin
        busy_q <= 1'b0;
        ph_q   <= ~ph_q;
        done_q <= 1'b1;
      end
    end
  end

  assign req_ready_o = ~busy_q;
  assign strobe_o    = strobe_q;
  assign data_o      = data_q;
  assign done_o      = done_q;

  a_r2_strobe_only_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(strobe_o));
  a_r3_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(data_o));
  a_r6_phase_line_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> !ack_i[ph_q]);
  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!req_ready_o));
endmodule

// File: rtl/hs_slave.sv
module hs_slave #(
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 1,
  localparam int unsigned CW = $clog2(LAT + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [DW-1:0] data_i,
  output logic [1:0]    ack_o,
  output logic [DW-1:0] cap_data_o,
  output logic          cap_valid_o
);
  logic          seen_q, ph_q, pend_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    ack_q;
  logic [DW-1:0] cap_q;
  logic          strobe_edge;

  assign strobe_edge = strobe_i ^ seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      ph_q    <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      ack_q   <= '0;
      cap_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (strobe_edge) begin
        seen_q        <= strobe_i;
        cap_q         <= data_i;
        valid_q       <= 1'b1;
        pend_q        <= 1'b1;
        cnt_q         <= CW'(LAT);
        ack_q[~ph_q]  <= 1'b0; // arm the idle line for the next transfer
      end else if (pend_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          ack_q[ph_q] <= 1'b1;
          pend_q      <= 1'b0;
          ph_q        <= ~ph_q;
        end
      end
    end
  end

  assign ack_o       = ack_q;
  assign cap_data_o  = cap_q;
  assign cap_valid_o = valid_q;

  a_r6_ack_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
  a_r4_capture_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i != $past(strobe_i)) |=> cap_valid_o);
endmodule

// File: rtl/hs_ack_and.sv
module hs_ack_and #(
  parameter int unsigned NS = 3
) (
  input  logic [NS-1:0] ack_even_i,
  input  logic [NS-1:0] ack_odd_i,
  output logic [1:0]    ack_o
);
  assign ack_o[0] = &ack_even_i;
  assign ack_o[1] = &ack_odd_i;
endmodule

// File: rtl/hs_bus.sv
module hs_bus #(
  parameter int unsigned DW       = 16,
  parameter int unsigned NS       = 3,
  parameter int unsigned LAT_BASE = 1,
  parameter int unsigned LAT_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DW-1:0]    req_data_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic             strobe_o,
  output logic [DW-1:0]    bus_data_o,
  output logic             ack_even_o,
  output logic             ack_odd_o,
  output logic [NS*DW-1:0] slv_data_o,
  output logic [NS-1:0]    slv_valid_o
);
  logic [NS-1:0] ack_even_v, ack_odd_v;
  logic [1:0]    ack_comb;

  hs_master #(.DW(DW)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_data_i  (req_data_i),
    .req_ready_o (req_ready_o),
    .ack_i       (ack_comb),
    .strobe_o    (strobe_o),
    .data_o      (bus_data_o),
    .done_o      (done_o)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slv
    logic [1:0] ack_s;
    hs_slave #(
      .DW  (DW),
      .LAT (hs_pkg::slave_lat(LAT_BASE, LAT_STEP, s))
    ) u_slave (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .strobe_i    (strobe_o),
      .data_i      (bus_data_o),
      .ack_o       (ack_s),
      .cap_data_o  (slv_data_o[s*DW +: DW]),
      .cap_valid_o (slv_valid_o[s])
    );
    assign ack_even_v[s] = ack_s[0];
    assign ack_odd_v[s]  = ack_s[1];
  end

  hs_ack_and #(.NS(NS)) u_and (
    .ack_even_i (ack_even_v),
    .ack_odd_i  (ack_odd_v),
    .ack_o      (ack_comb)
  );

  assign ack_even_o = ack_comb[0];
  assign ack_odd_o  = ack_comb[1];

  a_r7_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
  a_r6_lines_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_even_o && ack_odd_o));
endmodule

// File: tb/hs_bus_test.sv
`timescale 1ns/1ps
module hs_bus_test;
  localparam int unsigned DW = 16, NS = 3, LB = 1, LS = 2;
  localparam int unsigned LMAX = LB + (NS - 1) * LS;
  localparam int unsigned NV = 6;
  localparam logic [DW-1:0] VEC [NV] = '{16'hA5A5, 16'h0001, 16'hFFFF, 16'h1234, 16'h8000, 16'h5A0F};

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, strobe, ack_e, ack_o;
  logic [DW-1:0] bus_data;
  logic [NS*DW-1:0] slv_data;
  logic [NS-1:0] slv_valid;
  int checks = 0, errors = 0;
  logic exp_strobe = 0;

  always #2.5 clk = ~clk;

  hs_bus #(.DW(DW), .NS(NS), .LAT_BASE(LB), .LAT_STEP(LS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_data_i(req_data),
    .req_ready_o(req_ready), .done_o(done), .strobe_o(strobe), .bus_data_o(bus_data),
    .ack_even_o(ack_e), .ack_odd_o(ack_o), .slv_data_o(slv_data), .slv_valid_o(slv_valid));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_state(input string req);
    chk(strobe == 0 && ack_e == 0 && ack_o == 0 && done == 0 && req_ready == 1, req,
        {strobe, ack_e, ack_o, done, req_ready}, 5'b00001);
  endtask

  // one transfer; poke=1 raises a stray request mid-wait, abort_k>0 resets at that cycle
  task automatic xfer(input logic [DW-1:0] w, input bit poke, input int abort_k);
    bit ph_odd;
    ph_odd = exp_strobe; // strobe currently 1 -> next edge falling -> odd line
    @(negedge clk);
    req_valid = 1; req_data = w;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    exp_strobe = ~exp_strobe;
    chk(strobe == exp_strobe && bus_data == w && !req_ready, "R2 accept",
        {strobe, bus_data, req_ready}, {exp_strobe, w, 1'b0});
    chk(strobe == !ph_odd, "R6 strobe polarity", strobe, !ph_odd);
    for (int k = 1; k <= int'(LMAX) + 3; k++) begin
      if (poke && k == 3) begin req_valid = 1; req_data = ~w; end
      @(posedge clk); @(negedge clk);
      if (abort_k == k) begin
        rst_n = 0; req_valid = 0;
        #1;
        idle_state("R8 reset mid transfer");
        @(negedge clk); rst_n = 1;
        exp_strobe = 0;
        @(negedge clk);
        idle_state("R1 after mid reset");
        return;
      end
      if (poke && k == 4) begin
        chk(bus_data == w && strobe == exp_strobe, "R2 busy request ignored",
            {bus_data, strobe}, {w, exp_strobe});
        req_valid = 0;
      end
      chk(bus_data == w, "R3 data held", bus_data, w);
      if (k == 1) begin
        chk(slv_valid == '1, "R4 capture pulse", slv_valid, {NS{1'b1}});
        for (int s = 0; s < NS; s++)
          chk(slv_data[s*DW +: DW] == w, "R4 captured word", slv_data[s*DW +: DW], w);
      end
      if (k == 2) chk(slv_valid == '0, "R4 pulse one cycle", slv_valid, 0);
      if (k >= 2) chk((ph_odd ? ack_e : ack_o) == 0, "R6 other line cleared",
                      ph_odd ? ack_e : ack_o, 0);
      if (k == int'(LMAX) + 1)
        chk((ph_odd ? ack_o : ack_e) == 0, "R5 waits for slowest", ph_odd ? ack_o : ack_e, 0);
      if (k >= int'(LMAX) + 2)
        chk((ph_odd ? ack_o : ack_e) == 1, "R5 combined rise", ph_odd ? ack_o : ack_e, 1);
      chk(done == (k == int'(LMAX) + 3), "R7 done timing", done, k == int'(LMAX) + 3);
      if (k == int'(LMAX) + 3) chk(req_ready == 1, "R7 ready with done", req_ready, 1);
    end
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    idle_state("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    idle_state("R1 after reset");
    for (int i = 0; i < NV; i++) xfer(VEC[i], 1'b0, 0);
    xfer(16'hC3C3, 1'b1, 0);
    xfer(16'h7777, 1'b0, 4);
    xfer(16'h0F0F, 1'b0, 0); // R8: rising strobe, even line again
    xfer(16'hF0F0, 1'b1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule